// File: doc/BRIEF.md
# Cross-Neighbourhood Edge Filter

This block filters a raster stream of pixels on the fly. It takes one pixel per accepted cycle, in row-major order, from frames of fixed width. Two line memories hold the two rows before the current one. From them the block forms, for each pixel, a neighbourhood of the pixel itself (the centre) and its four direct neighbours: above, below, left and right. A small arithmetic stage turns that neighbourhood into a plain copy of the centre, an edge extraction or an edge enhancement, with the option to invert the result.

Static control inputs choose the mode, and they are held steady for a whole frame:
- The edge enable switches the edge processing on.
- The 2-bit direction field chooses which neighbours take part.
- A 4-bit ratio sets the weight of the edge term.
- An enhance bit chooses between an extraction around mid-grey and an enhancement added to the centre.
- An invert bit mirrors the final value.

Each result leaves through a register, and an output valid flag marks only the pixels that lie inside the effective region. That region depends on the mode. Frames are delimited by a start-of-frame marker on the first pixel.

Top module: `retina_edge_filter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `out_pix` is 0.
- R2: When `edge_on` is 0, or `edge_dir` is 00, each output equals the centre pixel unchanged.
- R3: When `edge_on` is 1 and `edge_dir` is 01 (horizontal) and `enhance` is 0, the output is 128 + floor((2C − L − R)·ratio/4). At the first column the missing left neighbour is replaced by C, and at the last column the missing right neighbour is replaced by C.
- R4: When `edge_on` is 1 and `edge_dir` is 10 (vertical) and `enhance` is 0, the output is 128 + floor((2C − U − D)·ratio/4). The region loses its first and last effective rows.
- R5: When `edge_on` is 1 and `edge_dir` is 11 (2-D) and `enhance` is 0, the output is 128 + floor((4C − U − D − L − R)·ratio/4). The region is trimmed in the same way as R4.
- R6: When `enhance` is 1 and edges are on, the constant 128 in R3 to R5 is replaced by the centre pixel C.
- R7: Every computed value is clamped to the range 0..255 before it is output.
- R8: When `invert` is 1, the output is 255 minus the clamped value, in every mode.
- R9: Outputs are produced in raster order of the centre position. The effective rows are EFF_FIRST .. EFF_FIRST+EFF_ROWS−1, with the trim of R4 and R5 applied where it holds, and every column is included. A pixel with `in_sof` high restarts the position at row 0, column 0.
- R10: Idle cycles between input pixels (`in_valid` low) do not change any output value, and they do not produce any extra valid output.
- R11: With `ratio` equal to 0, an extraction outputs 128, or 127 when inverted, and an enhancement outputs C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel strobe |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | PIX_W | Input pixel value |
| edge_on | input | 1 | Enables edge processing |
| edge_dir | input | 2 | 00 none, 01 horizontal, 10 vertical, 11 2-D |
| enhance | input | 1 | 1 adds the edge term to the centre; 0 adds it to mid-grey |
| ratio | input | RATIO_W | Edge weight, in quarters |
| invert | input | 1 | Mirrors the output value |
| out_valid | output | 1 | Output pixel lies in the effective region |
| out_pix | output | PIX_W | Filtered pixel |

## Verification
The bench uses several input patterns, and each one separates a different kind of fault:
- A diagonal ramp gives non-zero gradients in both axes, so swapping the vertical and horizontal neighbours changes the result.
- Column stripes and row stripes excite only one direction each, so they show whether the right pair of neighbours is used.
- A pseudo-random frame catches mistakes in the rounding of negative terms and in the weighting by the ratio.
- A full checkerboard at maximum ratio drives every term into clamping at both ends.

The same frames are also sent with idle gaps, and after a truncated frame, to show that the result depends only on pixel position.

// File: rtl/redge_pkg.sv
package redge_pkg;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_HORZ = 2'b01,
    DIR_VERT = 2'b10,
    DIR_BOTH = 2'b11
  } edge_dir_e;

endpackage

// File: rtl/redge_linebuf.sv
// One row of delay storage: a simple dual-port memory with a registered read.
// A read and a write to the same address in one cycle return the old word.
module redge_linebuf #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/redge_window.sv
// Tracks the raster position, keeps two row delays and column taps, and emits
// one five-pixel neighbourhood per accepted input pixel.
module redge_window #(
  parameter int LINE_W     = 128,
  parameter int FRAME_ROWS = 128,
  parameter int EFF_FIRST  = 2,
  parameter int EFF_ROWS   = 123,
  parameter int PIX_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             trim_rows,
  output logic             nb_stb,
  output logic             nb_eff,
  output logic [PIX_W-1:0] c_pix,
  output logic [PIX_W-1:0] n_pix,
  output logic [PIX_W-1:0] s_pix,
  output logic [PIX_W-1:0] w_pix,
  output logic [PIX_W-1:0] e_pix
);

  localparam int COL_W = (LINE_W > 1) ? $clog2(LINE_W) : 1;
  localparam int ROW_W = $clog2(FRAME_ROWS + 4) + 1;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_W - 1);
  localparam logic [ROW_W-1:0] ROW_SAT  = '1;

  // raster position of the incoming pixel
  logic [COL_W-1:0] col_nxt, cur_col, col1;
  logic [ROW_W-1:0] row_nxt, cur_row, row1;

  assign cur_col = in_sof ? '0 : col_nxt;
  assign cur_row = in_sof ? '0 : row_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_nxt <= '0;
      row_nxt <= '0;
    end else if (in_valid) begin
      if (cur_col == COL_LAST) begin
        col_nxt <= '0;
        row_nxt <= (cur_row == ROW_SAT) ? cur_row : cur_row + 1'b1;
      end else begin
        col_nxt <= cur_col + 1'b1;
        row_nxt <= cur_row;
      end
    end
  end

  // stage 1: row delays
  logic             v1;
  logic [PIX_W-1:0] pix1, mid_q, top_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      col1 <= '0;
      row1 <= '0;
      pix1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        col1 <= cur_col;
        row1 <= cur_row;
        pix1 <= in_pix;
      end
    end
  end

  redge_linebuf #(.DEPTH(LINE_W), .DATA_W(PIX_W), .ADDR_W(COL_W)) u_line_mid (
    .clk     (clk),
    .wr_en   (in_valid),
    .wr_addr (cur_col),
    .wr_data (in_pix),
    .rd_en   (in_valid),
    .rd_addr (cur_col),
    .rd_data (mid_q)
  );

  redge_linebuf #(.DEPTH(LINE_W), .DATA_W(PIX_W), .ADDR_W(COL_W)) u_line_top (
    .clk     (clk),
    .wr_en   (v1),
    .wr_addr (col1),
    .wr_data (mid_q),
    .rd_en   (in_valid),
    .rd_addr (cur_col),
    .rd_data (top_q)
  );

  // stage 2: column taps and neighbourhood selection
  logic [PIX_W-1:0] top_t0, bot_t0, mid_t0, mid_t1;
  int row_lo, row_hi, row_i;
  logic eff_wrap, eff_norm;

  always_comb begin
    row_lo   = EFF_FIRST + (trim_rows ? 1 : 0);
    row_hi   = EFF_FIRST + EFF_ROWS - 1 - (trim_rows ? 1 : 0);
    row_i    = int'(row1);
    // a pixel in column 0 closes the last column of the row two rows up
    eff_wrap = (row_i >= row_lo + 2) && (row_i <= row_hi + 2);
    eff_norm = (row_i >= row_lo + 1) && (row_i <= row_hi + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nb_stb <= 1'b0;
      nb_eff <= 1'b0;
      c_pix  <= '0;
      n_pix  <= '0;
      s_pix  <= '0;
      w_pix  <= '0;
      e_pix  <= '0;
      top_t0 <= '0;
      bot_t0 <= '0;
      mid_t0 <= '0;
      mid_t1 <= '0;
    end else begin
      nb_stb <= v1;
      if (v1) begin
        c_pix <= mid_t0;
        n_pix <= top_t0;
        s_pix <= bot_t0;
        if (col1 == '0) begin
          w_pix  <= mid_t1;
          e_pix  <= mid_t0;
          nb_eff <= eff_wrap;
        end else begin
          w_pix  <= (col1 == COL_W'(1)) ? mid_t0 : mid_t1;
          e_pix  <= mid_q;
          nb_eff <= eff_norm;
        end
        top_t0 <= top_q;
        bot_t0 <= pix1;
        mid_t0 <= mid_q;
        mid_t1 <= mid_t0;
      end else begin
        nb_eff <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/redge_core.sv
// Combinational arithmetic: edge term, weighting, base selection, clamp, invert.
module redge_core
  import redge_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int RATIO_W   = 4,
  parameter int FRAC_BITS = 2
) (
  input  logic [PIX_W-1:0]   c_pix,
  input  logic [PIX_W-1:0]   n_pix,
  input  logic [PIX_W-1:0]   s_pix,
  input  logic [PIX_W-1:0]   w_pix,
  input  logic [PIX_W-1:0]   e_pix,
  input  logic               edge_on,
  input  edge_dir_e          dir,
  input  logic               enhance,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               invert,
  output logic [PIX_W-1:0]   result
);

  localparam int ACC_W = PIX_W + RATIO_W + 5;
  localparam logic signed [ACC_W-1:0] MID  = ACC_W'(1 << (PIX_W - 1));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] cs, ns, ss, ws, es, rs;
  logic signed [ACC_W-1:0] diff, prod, scaled, raw;
  logic        [PIX_W-1:0] clipped;

  assign cs = signed'({{(ACC_W-PIX_W){1'b0}}, c_pix});
  assign ns = signed'({{(ACC_W-PIX_W){1'b0}}, n_pix});
  assign ss = signed'({{(ACC_W-PIX_W){1'b0}}, s_pix});
  assign ws = signed'({{(ACC_W-PIX_W){1'b0}}, w_pix});
  assign es = signed'({{(ACC_W-PIX_W){1'b0}}, e_pix});
  assign rs = signed'({{(ACC_W-RATIO_W){1'b0}}, ratio});

  always_comb begin
    case (dir)
      DIR_HORZ: diff = (cs <<< 1) - ws - es;
      DIR_VERT: diff = (cs <<< 1) - ns - ss;
      DIR_BOTH: diff = (cs <<< 2) - ns - ss - ws - es;
      default:  diff = '0;
    endcase
    prod   = diff * rs;
    scaled = prod >>> FRAC_BITS;
    if (edge_on && (dir != DIR_NONE)) raw = (enhance ? cs : MID) + scaled;
    else                              raw = cs;
    if (raw < 0)         clipped = '0;
    else if (raw > MAXV) clipped = '1;
    else                 clipped = raw[PIX_W-1:0];
    result = invert ? ~clipped : clipped;
  end

endmodule

// File: rtl/retina_edge_filter.sv
module retina_edge_filter
  import redge_pkg::*;
#(
  parameter int LINE_W     = 128,
  parameter int FRAME_ROWS = 128,
  parameter int EFF_FIRST  = 2,
  parameter int EFF_ROWS   = 123,
  parameter int PIX_W      = 8,
  parameter int RATIO_W    = 4,
  parameter int FRAC_BITS  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic [PIX_W-1:0]   in_pix,
  input  logic               edge_on,
  input  logic [1:0]         edge_dir,
  input  logic               enhance,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               invert,
  output logic               out_valid,
  output logic [PIX_W-1:0]   out_pix
);

  logic             nb_stb, nb_eff, trim_rows;
  logic [PIX_W-1:0] c_pix, n_pix, s_pix, w_pix, e_pix, result;
  edge_dir_e        dir;

  assign dir       = edge_dir_e'(edge_dir);
  assign trim_rows = edge_on && edge_dir[1];

  redge_window #(
    .LINE_W(LINE_W), .FRAME_ROWS(FRAME_ROWS), .EFF_FIRST(EFF_FIRST),
    .EFF_ROWS(EFF_ROWS), .PIX_W(PIX_W)
  ) u_window (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_pix    (in_pix),
    .trim_rows (trim_rows),
    .nb_stb    (nb_stb),
    .nb_eff    (nb_eff),
    .c_pix     (c_pix),
    .n_pix     (n_pix),
    .s_pix     (s_pix),
    .w_pix     (w_pix),
    .e_pix     (e_pix)
  );

  redge_core #(.PIX_W(PIX_W), .RATIO_W(RATIO_W), .FRAC_BITS(FRAC_BITS)) u_core (
    .c_pix   (c_pix),
    .n_pix   (n_pix),
    .s_pix   (s_pix),
    .w_pix   (w_pix),
    .e_pix   (e_pix),
    .edge_on (edge_on),
    .dir     (dir),
    .enhance (enhance),
    .ratio   (ratio),
    .invert  (invert),
    .result  (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= nb_stb && nb_eff;
      if (nb_stb) out_pix <= result;
    end
  end

endmodule

// File: rtl/redge_checker.sv
module redge_checker #(
  parameter int PIX_W   = 8,
  parameter int RATIO_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               edge_on,
  input logic [1:0]         edge_dir,
  input logic               enhance,
  input logic [RATIO_W-1:0] ratio,
  input logic               invert,
  input logic               out_valid,
  input logic [PIX_W-1:0]   out_pix
);

  localparam logic [PIX_W-1:0] MIDV = PIX_W'(1 << (PIX_W - 1));

  AST_RST_VALID: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> !out_valid); // R1
  AST_RST_PIX: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (out_pix == '0)); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid, 3)); // R10
  AST_FLAT_EXTRACT: assert property (@(posedge clk) disable iff (rst)
    (edge_on && edge_dir != 2'b00 && !enhance && !invert && ratio == '0) |=> (!out_valid || out_pix == MIDV)); // R11
  AST_FLAT_INVERT: assert property (@(posedge clk) disable iff (rst)
    (edge_on && edge_dir != 2'b00 && !enhance && invert && ratio == '0) |=> (!out_valid || out_pix == ~MIDV)); // R8

endmodule

bind retina_edge_filter redge_checker #(.PIX_W(PIX_W), .RATIO_W(RATIO_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .edge_on   (edge_on),
  .edge_dir  (edge_dir),
  .enhance   (enhance),
  .ratio     (ratio),
  .invert    (invert),
  .out_valid (out_valid),
  .out_pix   (out_pix)
);

// File: tb/retina_edge_filter_tb_top.sv
module retina_edge_filter_tb_top;

  localparam int LW = 16;
  localparam int FR = 12;
  localparam int EF = 2;
  localparam int ER = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_pix = '0;
  logic       edge_on = 1'b0, enhance = 1'b0, invert = 1'b0;
  logic [1:0] edge_dir = 2'b00;
  logic [3:0] ratio = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  int checks = 0, fails = 0;
  bit done = 0;
  int img [FR][LW];
  int got [$];
  int lcg = 12345;

  always #4 clk = ~clk;

  retina_edge_filter #(
    .LINE_W(LW), .FRAME_ROWS(FR), .EFF_FIRST(EF), .EFF_ROWS(ER)
  ) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
    .edge_on(edge_on), .edge_dir(edge_dir), .enhance(enhance), .ratio(ratio),
    .invert(invert), .out_valid(out_valid), .out_pix(out_pix)
  );

  always @(negedge clk) if (!rst && out_valid) got.push_back(int'(out_pix));

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pat_px(int pat, int r, int c);
    case (pat)
      0: return (r * 37 + c * 11) & 255;
      1: return ((r + c) % 2 == 1) ? 255 : 0;
      3: return (c % 4 < 2) ? 200 : 40;
      4: return (r % 2 == 1) ? 230 : 20;
      default: begin
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return (lcg >> 16) & 255;
      end
    endcase
  endfunction

  function automatic int ref_px(int r, int c);
    int p, n, s, w, e, d, v;
    p = img[r][c]; n = img[r-1][c]; s = img[r+1][c];
    w = (c == 0) ? p : img[r][c-1];
    e = (c == LW - 1) ? p : img[r][c+1];
    if (!edge_on || edge_dir == 2'b00) v = p;
    else begin
      case (edge_dir)
        2'b01:   d = 2 * p - w - e;
        2'b10:   d = 2 * p - n - s;
        default: d = 4 * p - n - s - w - e;
      endcase
      d = (d * int'(ratio)) >>> 2;
      v = (enhance ? p : 128) + d;
    end
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    if (invert) v = 255 - v;
    return v;
  endfunction

  task automatic stream(int nrows, bit gaps);
    for (int r = 0; r < nrows; r++)
      for (int c = 0; c < LW; c++) begin
        if (gaps && (c % 3 == 1)) begin
          @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (r == 0 && c == 0);
        in_pix   = 8'(img[r][c]);
      end
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_mode(bit on, int dir, bit enh, int rat, bit inv);
    @(negedge clk);
    edge_on = on; edge_dir = 2'(dir); enhance = enh; ratio = 4'(rat); invert = inv;
  endtask

  task automatic fill(int pat);
    for (int r = 0; r < FR; r++)
      for (int c = 0; c < LW; c++) img[r][c] = pat_px(pat, r, c);
  endtask

  // compares the collected outputs against the raster of effective centres
  task automatic compare(string tag, string name);
    int lo, hi, n_exp, idx, bad_i, bad_a, bad_e;
    bit ok;
    lo = EF + ((edge_on && edge_dir[1]) ? 1 : 0);
    hi = EF + ER - 1 - ((edge_on && edge_dir[1]) ? 1 : 0);
    n_exp = (hi - lo + 1) * LW;
    check(got.size() == n_exp, tag, {name, " output count"}, got.size(), n_exp);
    ok = 1; idx = 0; bad_i = 0; bad_a = 0; bad_e = 0;
    for (int r = lo; r <= hi; r++)
      for (int c = 0; c < LW; c++) begin
        if (idx < got.size() && ok && got[idx] != ref_px(r, c)) begin
          ok = 0; bad_i = idx; bad_a = got[idx]; bad_e = ref_px(r, c);
        end
        idx++;
      end
    if (!ok) $display("  first mismatch at output index %0d", bad_i);
    check(ok, tag, {name, " pixel values"}, bad_a, bad_e);
  endtask

  task automatic run_case(string tag, string name, int pat, bit on, int dir,
                          bit enh, int rat, bit inv, bit gaps);
    set_mode(on, dir, enh, rat, inv);
    fill(pat);
    got.delete();
    stream(FR, gaps);
    compare(tag, name);
  endtask

  task automatic t_reset();  // R1
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    check(out_pix == 8'd0, "R1", "pixel after reset", int'(out_pix), 0);
  endtask

  task automatic t_positive();  // R2
    run_case("R2", "pass-through edges off", 0, 0, 3, 0, 9, 0, 0);
    run_case("R2", "pass-through dir none", 2, 1, 0, 1, 9, 0, 0);
  endtask

  task automatic t_horizontal();  // R3
    run_case("R3", "horizontal extract random", 2, 1, 1, 0, 4, 0, 0);
    run_case("R3", "horizontal extract stripes", 3, 1, 1, 0, 6, 0, 0);
  endtask

  task automatic t_vertical();  // R4
    run_case("R4", "vertical extract ramp", 0, 1, 2, 0, 7, 0, 0);
    run_case("R4", "vertical extract row stripes", 4, 1, 2, 0, 3, 0, 0);
  endtask

  task automatic t_twod();  // R5
    run_case("R5", "2-D extract random", 2, 1, 3, 0, 5, 0, 0);
  endtask

  task automatic t_enhance();  // R6
    run_case("R6", "2-D enhance random", 2, 1, 3, 1, 5, 0, 0);
    run_case("R6", "horizontal enhance ramp", 0, 1, 1, 1, 11, 0, 0);
  endtask

  task automatic t_saturate();  // R7
    run_case("R7", "2-D extract checkerboard", 1, 1, 3, 0, 15, 0, 0);
    run_case("R7", "vertical enhance checkerboard", 1, 1, 2, 1, 15, 0, 0);
  endtask

  task automatic t_invert();  // R8
    run_case("R8", "inverted pass-through", 0, 0, 0, 0, 0, 1, 0);
    run_case("R8", "inverted 2-D enhance", 2, 1, 3, 1, 8, 1, 0);
  endtask

  task automatic t_restart();  // R9
    set_mode(1, 3, 0, 6, 0);
    fill(0);
    stream(5, 0);
    got.delete();
    fill(3);
    stream(FR, 0);
    compare("R9", "frame after truncated frame");
  endtask

  task automatic t_gaps();  // R10
    run_case("R10", "2-D extract with idle gaps", 2, 1, 3, 0, 9, 0, 1);
    run_case("R10", "vertical enhance with idle gaps", 0, 1, 2, 1, 13, 0, 1);
  endtask

  task automatic t_ratio_zero();  // R11
    run_case("R11", "zero ratio extract", 2, 1, 3, 0, 0, 0, 0);
    run_case("R11", "zero ratio extract inverted", 2, 1, 1, 0, 0, 1, 0);
    run_case("R11", "zero ratio enhance", 2, 1, 2, 1, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WATCHDOG", "run completed", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    t_positive();
    t_horizontal();
    t_vertical();
    t_twod();
    t_enhance();
    t_saturate();
    t_invert();
    t_restart();
    t_gaps();
    t_ratio_zero();
    finish_run();
  end

endmodule